// File: doc/BRIEF.md
# Calorimeter Flash-ADC Pulse Processor

This block is the digital front end of a calorimeter trigger. Twelve trigger-cell channels each deliver one digitised sample of a shaped analog sum per sample period, all on one parallel bus qualified by a single valid strobe. Each channel watches for a pulse rising above a shared pedestal level. When the pulse turns over, the channel extracts one amplitude. A per-channel mode bit chooses whether that amplitude is the above-pedestal peak height or the running sum of above-pedestal samples over the rising edge.

The raw amplitude is then gain-corrected through a per-channel lookup table and compared against a programmable hit threshold. All twelve channels are packed into one frame word together with the sample-period timestamp of the peak. Each frame passes through a programmable latency-equalising delay before it leaves the block. Software-side loading of the tables uses a plain address, data and write-enable port. The serial link that carries the frame lies outside the block.

Top module: `calo_pulse_proc`

## Requirements
- R1: While reset is asserted, and until the first accepted sample after its release, `frame_valid` is 0 and `frame_data` is all zero.
- R2: In peak mode (mode bit 0), a pulse starts at the first sample strictly above `cfg_ped`. The peak is declared at the first later sample that is strictly lower than its predecessor; equal samples continue the rise. The raw amplitude is the largest sample minus `cfg_ped`.
- R3: In sum mode (mode bit 1), the raw amplitude is the sum of (sample − `cfg_ped`) from the pulse-start sample up to and including the largest sample.
- R4: The sum-mode amplitude saturates at 16383 (all ones in 14 bits) and does not wrap.
- R5: The reported height equals entry k of that channel's table, where k = ceil(raw / 256) capped at 63.
- R6: A channel's hit bit is set only when its corrected height is at least `cfg_hit_thr`; a channel without a hit reports an all-zero field. Channel c occupies `frame_data[13c+12:13c]`, with the hit bit at 13c+12 and the height in the low 12 bits.
- R7: `frame_data[163:156]` holds the index, modulo 256, of the peak sample, counting accepted samples from 0 after reset.
- R8: With a continuous valid strobe, the frame for a peak appears 3 + `cfg_delay` clock edges after the edge that accepts the declaring sample, for `cfg_delay` from 0 to 31. `frame_valid` pulses once per accepted sample.
- R9: After a peak, a channel declares no further peak until a sample at or below `cfg_ped` has been seen.
- R10: When `lut_we` is high, `lut_wdata` is written to entry `lut_addr` of the table selected by `lut_ch`. A lookup in the same cycle as a write to that entry returns the old value.
- R11: Channels are processed independently, each under its own bit of `cfg_mode`, and peaks on several channels in the same sample share one frame.
- R12: While `in_valid` is low, the samples are ignored, no processing state advances, and `frame_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | One sample per channel is present this cycle |
| in_samples | input | 144 | Channel c sample at bits [12c+11:12c] |
| cfg_ped | input | 12 | Pedestal level shared by all channels |
| cfg_mode | input | 12 | Per-channel amplitude mode: 0 peak, 1 rising-edge sum |
| cfg_hit_thr | input | 12 | Discriminator threshold on the corrected height |
| cfg_delay | input | 5 | Extra latency in samples before output |
| lut_we | input | 1 | Table write enable |
| lut_ch | input | 4 | Table (channel) selected for writing |
| lut_addr | input | 6 | Table entry written |
| lut_wdata | input | 12 | Value written |
| frame_valid | output | 1 | A new frame is on `frame_data` |
| frame_data | output | 164 | Packed frame: 12 channel fields and the timestamp |

## Verification
On every cycle, the assertions confirm that a field without a hit bit carries zero height and that a channel never reports peaks on two consecutive accepted samples. They also confirm that the pipeline output and the packed stage hold still whenever no sample is accepted. The amplitude arithmetic cannot be shown this way; only the bench scenarios can show it. These cover the peak-versus-sum choice, saturation, the table indexing, the same-cycle table write, the timestamp value, the exact latency under two delay settings, re-arming below the pedestal, and results with gaps in the valid strobe.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RISE = 2'd1,
    ST_WAIT = 2'd2
  } det_st_e;
endpackage

// File: rtl/cpp_pulse_det.sv
// One channel: pedestal crossing, turn-over detection, peak or rising-edge sum.
module cpp_pulse_det #(
  parameter int SW = 12,
  parameter int RW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [SW-1:0] sample,
  input  logic [SW-1:0] ped,
  input  logic          sum_mode,
  output logic          pk_stb,
  output logic [RW-1:0] pk_amp
);
  import cpp_pkg::*;

  localparam int XW = RW + 1 - SW;

  det_st_e       st_q, st_d;
  logic [SW-1:0] prev_q, prev_d;
  logic [RW-1:0] acc_q, acc_d;
  logic          stb_d;
  logic [RW-1:0] amp_d;
  logic          above;
  logic [SW-1:0] excess;
  logic [SW-1:0] top_amp;
  logic [RW:0]   acc_sum;
  logic [RW-1:0] acc_sat;

  always_comb begin
    above   = sample > ped;
    excess  = sample - ped;
    top_amp = prev_q - ped;
    acc_sum = {1'b0, acc_q} + {{XW{1'b0}}, excess};
    acc_sat = acc_sum[RW] ? {RW{1'b1}} : acc_sum[RW-1:0];

    st_d   = st_q;
    prev_d = prev_q;
    acc_d  = acc_q;
    stb_d  = 1'b0;
    amp_d  = '0;
    case (st_q)
      ST_IDLE: begin
        if (above) begin
          st_d   = ST_RISE;
          prev_d = sample;
          acc_d  = {{(RW-SW){1'b0}}, excess};
        end
      end
      ST_RISE: begin
        if (sample < prev_q) begin
          stb_d = 1'b1;
          amp_d = sum_mode ? acc_q : {{(RW-SW){1'b0}}, top_amp};
          st_d  = above ? ST_WAIT : ST_IDLE;
        end else begin
          prev_d = sample;
          acc_d  = acc_sat;
        end
      end
      ST_WAIT: begin
        if (!above) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      prev_q <= '0;
      acc_q  <= '0;
      pk_stb <= 1'b0;
      pk_amp <= '0;
    end else if (ce) begin
      st_q   <= st_d;
      prev_q <= prev_d;
      acc_q  <= acc_d;
      pk_stb <= stb_d;
      pk_amp <= amp_d;
    end
  end
endmodule

// File: rtl/cpp_gain_lut.sv
// Per-channel gain table: write port for configuration, registered read on sample enable.
module cpp_gain_lut #(
  parameter int AW = 6,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // Datapath storage, no reset: contents are loaded through the write port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (ce) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cpp_delay_line.sv
// Programmable frame delay built on a circular buffer with a fill count.
module cpp_delay_line #(
  parameter int W   = 164,
  parameter int DAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic [W-1:0]   din,
  input  logic [DAW-1:0] dly,
  output logic [W-1:0]   dout,
  output logic           dout_vld
);
  localparam int DEPTH = 2 ** DAW;

  logic [W-1:0]   mem [DEPTH];
  logic [DAW-1:0] wp_q, wp_d;
  logic [DAW-1:0] fill_q, fill_d;
  logic [DAW-1:0] rp;
  logic [W-1:0]   sel;

  always_comb begin
    rp     = wp_q - dly;
    wp_d   = wp_q + 1'b1;
    fill_d = (fill_q == {DAW{1'b1}}) ? fill_q : fill_q + 1'b1;
    if (dly == '0)          sel = din;
    else if (fill_q >= dly) sel = mem[rp];
    else                    sel = '0;
  end

  always_ff @(posedge clk) begin
    if (ce) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q     <= '0;
      fill_q   <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= ce;
      if (ce) begin
        wp_q   <= wp_d;
        fill_q <= fill_d;
        dout   <= sel;
      end
    end
  end
endmodule

// File: rtl/calo_pulse_proc.sv
module calo_pulse_proc #(
  parameter int NCH    = 12,
  parameter int SW     = 12,
  parameter int RW     = 14,
  parameter int GW     = 12,
  parameter int LUT_AW = 6,
  parameter int TSW    = 8,
  parameter int DAW    = 5,
  localparam int CHW   = $clog2(NCH),
  localparam int FLDW  = GW + 1,
  localparam int FW    = NCH * FLDW + TSW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NCH*SW-1:0] in_samples,
  input  logic [SW-1:0]     cfg_ped,
  input  logic [NCH-1:0]    cfg_mode,
  input  logic [GW-1:0]     cfg_hit_thr,
  input  logic [DAW-1:0]    cfg_delay,
  input  logic              lut_we,
  input  logic [CHW-1:0]    lut_ch,
  input  logic [LUT_AW-1:0] lut_addr,
  input  logic [GW-1:0]     lut_wdata,
  output logic              frame_valid,
  output logic [FW-1:0]     frame_data
);
  localparam int LSH = RW - LUT_AW;

  logic [1:0]     rs_q;
  logic           rst_q_n;
  logic           ce;
  logic [TSW-1:0] ts_cnt_q, s1_ts_q, s2_ts_q;
  logic [NCH-1:0] pk_stb;
  logic [RW-1:0]  pk_amp [NCH];
  logic [NCH-1:0] s2_pk_q;
  logic [GW-1:0]  corr [NCH];
  logic [FW-1:0]  frame_d, frame_q;

  assign ce = in_valid;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [LUT_AW:0]   idx_up;
    logic [LUT_AW-1:0] idx;
    logic              we_c;

    cpp_pulse_det #(.SW(SW), .RW(RW)) u_det (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .ce      (ce),
      .sample  (in_samples[c*SW +: SW]),
      .ped     (cfg_ped),
      .sum_mode(cfg_mode[c]),
      .pk_stb  (pk_stb[c]),
      .pk_amp  (pk_amp[c])
    );

    // Ceiling bin of the raw amplitude, capped at the last entry.
    always_comb begin
      idx_up = {1'b0, pk_amp[c][RW-1:LSH]} + {{LUT_AW{1'b0}}, |pk_amp[c][LSH-1:0]};
      idx    = idx_up[LUT_AW] ? {LUT_AW{1'b1}} : idx_up[LUT_AW-1:0];
      we_c   = lut_we && (lut_ch == CHW'(c));
    end

    cpp_gain_lut #(.AW(LUT_AW), .DW(GW)) u_lut (
      .clk  (clk),
      .ce   (ce),
      .we   (we_c),
      .waddr(lut_addr),
      .wdata(lut_wdata),
      .raddr(idx),
      .rdata(corr[c])
    );
  end

  always_comb begin
    frame_d = '0;
    for (int c = 0; c < NCH; c++) begin
      if (s2_pk_q[c] && (corr[c] >= cfg_hit_thr))
        frame_d[c*FLDW +: FLDW] = {1'b1, corr[c]};
    end
    frame_d[FW-1 -: TSW] = s2_ts_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ts_cnt_q <= '0;
      s1_ts_q  <= '0;
      s2_ts_q  <= '0;
      s2_pk_q  <= '0;
      frame_q  <= '0;
    end else if (ce) begin
      ts_cnt_q <= ts_cnt_q + 1'b1;
      s1_ts_q  <= ts_cnt_q - 1'b1;
      s2_ts_q  <= s1_ts_q;
      s2_pk_q  <= pk_stb;
      frame_q  <= frame_d;
    end
  end

  cpp_delay_line #(.W(FW), .DAW(DAW)) u_dly (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ce      (ce),
    .din     (frame_q),
    .dly     (cfg_delay),
    .dout    (frame_data),
    .dout_vld(frame_valid)
  );
endmodule

// File: rtl/cpp_checker.sv
module cpp_checker #(
  parameter int NCH = 12,
  parameter int GW  = 12,
  parameter int FW  = 164
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [NCH-1:0] pk_stb,
  input logic [FW-1:0]  frame_q,
  input logic           frame_valid,
  input logic [FW-1:0]  frame_data
);
  localparam int FLDW = GW + 1;

  // R12: output frame held while no sample is accepted
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(frame_data));

  // R12: packed stage ignores table writes and samples while idle
  assert_stage_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(frame_q));

  for (genvar c = 0; c < NCH; c++) begin : g_a
    // R9: a peak is never followed by another on the next accepted sample
    assert_single_peak_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pk_stb[c] && in_valid) |=> !pk_stb[c]);

    // R6: a field without hit bit carries zero height
    assert_nohit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && !frame_data[c*FLDW + GW]) |-> (frame_data[c*FLDW +: GW] == '0));
  end
endmodule

bind calo_pulse_proc cpp_checker #(.NCH(NCH), .GW(GW), .FW(FW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .in_valid   (in_valid),
  .pk_stb     (pk_stb),
  .frame_q    (frame_q),
  .frame_valid(frame_valid),
  .frame_data (frame_data)
);

// File: tb/calo_pulse_proc_tb.sv
module calo_pulse_proc_tb;
  localparam int NCH = 12, SW = 12, GW = 12, FLDW = 13, FW = 164;

  // Stimulus table: channel, mode, pedestal, six samples, position of peak, raw amplitude
  localparam int NR = 6;
  localparam int T_CH  [NR] = '{0, 3, 7, 11, 5, 9};
  localparam int T_MD  [NR] = '{0, 1, 0, 1, 1, 0};
  localparam int T_PED [NR] = '{100, 100, 0, 0, 50, 2000};
  localparam int T_S   [NR][6] = '{
    '{100, 300, 900, 1500, 1200, 400},
    '{100, 300, 900, 1500, 1200, 400},
    '{0, 50, 4095, 4095, 100, 0},
    '{4095, 4095, 4095, 4095, 4095, 0},
    '{60, 70, 80, 90, 85, 0},
    '{1000, 2500, 3000, 2900, 0, 0}};
  localparam int T_PK  [NR] = '{3, 3, 3, 4, 3, 2};
  localparam int T_RAW [NR] = '{1400, 2400, 4095, 16383, 100, 1000};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [NCH*SW-1:0] in_samples;
  logic [SW-1:0]     cfg_ped;
  logic [NCH-1:0]    cfg_mode;
  logic [GW-1:0]     cfg_hit_thr;
  logic [4:0]        cfg_delay;
  logic              lut_we;
  logic [3:0]        lut_ch;
  logic [5:0]        lut_addr;
  logic [GW-1:0]     lut_wdata;
  logic              frame_valid;
  logic [FW-1:0]     frame_data;

  int n_chk = 0, n_fail = 0, cyc = 0, sidx = 0, cur_idx = 0, last_cyc = 0;
  int pidx = 0, dcyc = 0;
  int samp [NCH];
  int cap_n [NCH], cap_h [NCH], cap_ts [NCH], cap_cyc [NCH];
  logic [FLDW-1:0] fld;
  bit done = 0;

  calo_pulse_proc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
    .cfg_ped(cfg_ped), .cfg_mode(cfg_mode), .cfg_hit_thr(cfg_hit_thr),
    .cfg_delay(cfg_delay), .lut_we(lut_we), .lut_ch(lut_ch), .lut_addr(lut_addr),
    .lut_wdata(lut_wdata), .frame_valid(frame_valid), .frame_data(frame_data));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (frame_valid) begin
      for (int c = 0; c < NCH; c++) begin
        fld = frame_data[c*FLDW +: FLDW];
        if (fld != '0) begin
          cap_n[c]++;
          cap_h[c]   = int'(fld[GW-1:0]) + (fld[GW] ? 0 : 100000);
          cap_ts[c]  = int'(frame_data[FW-1 -: 8]);
          cap_cyc[c] = cyc;
        end
      end
    end
  end

  function automatic int lut_val(input int ch, input int raw);
    int k = (raw + 255) / 256;
    if (k > 63) k = 63;
    return k * 32 + ch;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_cap();
    for (int c = 0; c < NCH; c++) begin
      cap_n[c] = 0; cap_h[c] = -1; cap_ts[c] = -1; cap_cyc[c] = -1;
    end
  endtask

  task automatic push();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) in_samples[c*SW +: SW] = samp[c][SW-1:0];
    in_valid = 1'b1;
    last_cyc = cyc + 1;
    cur_idx  = sidx;
    sidx++;
  endtask

  task automatic push_one(input int ch, input int v);
    for (int c = 0; c < NCH; c++) samp[c] = 0;
    samp[ch] = v;
    push();
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid   = 1'b0;
    in_samples = '1;
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) push_one(0, 0);
  endtask

  task automatic run_row(input int r);
    cfg_ped  = T_PED[r][SW-1:0];
    cfg_mode = '0;
    cfg_mode[T_CH[r]] = T_MD[r][0];
    clear_cap();
    flush(2);
    for (int j = 0; j < 6; j++) begin
      push_one(T_CH[r], T_S[r][j]);
      if (j == T_PK[r]) pidx = cur_idx;
      if (j == T_PK[r] + 1) dcyc = last_cyc;
    end
    flush(40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_samples = '0; cfg_ped = '0; cfg_mode = '0;
    cfg_hit_thr = '0; cfg_delay = '0; lut_we = 1'b0; lut_ch = '0; lut_addr = '0;
    lut_wdata = '0;
    clear_cap();
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(frame_valid), 0);
    chk("R1 data in reset", int'(frame_data != '0), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid before first sample", int'(frame_valid), 0);
    chk("R1 data before first sample", int'(frame_data != '0), 0);

    // R10: load every table with entry k = 32k + channel
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 64; k++) begin
        @(negedge clk);
        lut_we = 1'b1; lut_ch = 4'(c); lut_addr = 6'(k); lut_wdata = 12'(k * 32 + c);
      end
    end
    @(negedge clk);
    lut_we = 1'b0;

    // Vector table walk: R2, R3, R4, R5, R7, R8, R11
    for (int r = 0; r < NR; r++) begin
      string tag;
      int others;
      tag = (r == 3) ? "R4" : (T_MD[r] != 0 ? "R3" : "R2");
      run_row(r);
      chk({tag, " hit count"}, cap_n[T_CH[r]], 1);
      chk({"R5 height ", tag}, cap_h[T_CH[r]], lut_val(T_CH[r], T_RAW[r]));
      chk("R7 timestamp", cap_ts[T_CH[r]], pidx % 256);
      chk("R8 latency delay 0", cap_cyc[T_CH[r]] - dcyc, 3);
      others = 0;
      for (int c = 0; c < NCH; c++) if (c != T_CH[r]) others += cap_n[c];
      chk("R11 other channels quiet", others, 0);
    end

    // R8: delay of 17 samples
    cfg_delay = 5'd17;
    run_row(1);
    chk("R8 latency delay 17", cap_cyc[3] - dcyc, 20);
    chk("R8 height after delay", cap_h[3], lut_val(3, 2400));
    cfg_delay = 5'd0;

    // R6: threshold equal passes, one above suppresses
    cfg_hit_thr = 12'(lut_val(0, 1400));
    run_row(0);
    chk("R6 threshold equal hit", cap_h[0], lut_val(0, 1400));
    cfg_hit_thr = 12'(lut_val(0, 1400) + 1);
    run_row(0);
    chk("R6 below threshold field zero", cap_n[0], 0);
    cfg_hit_thr = '0;

    // R9: second rise while above pedestal is ignored, re-arm after dip
    cfg_ped = 12'd100; cfg_mode = '0; clear_cap();
    flush(2);
    push_one(2, 500); push_one(2, 800); push_one(2, 600); push_one(2, 900);
    push_one(2, 1000); push_one(2, 700); push_one(2, 50); push_one(2, 0);
    push_one(2, 300); push_one(2, 200);
    flush(20);
    chk("R9 peaks after re-arm", cap_n[2], 2);
    chk("R9 second peak height", cap_h[2], lut_val(2, 200));

    // R11: all channels peak together, mixed modes
    cfg_ped = '0; cfg_mode = 12'b1010_1010_1010; clear_cap();
    flush(2);
    for (int c = 0; c < NCH; c++) samp[c] = 64 * (c + 1);
    push();
    for (int c = 0; c < NCH; c++) samp[c] = 128 * (c + 1);
    push();
    pidx = cur_idx;
    flush(20);
    for (int c = 0; c < NCH; c++) begin
      chk("R11 shared frame height", cap_h[c],
          lut_val(c, (c % 2 == 1) ? 192 * (c + 1) : 128 * (c + 1)));
      chk("R11 shared timestamp", cap_ts[c], pidx % 256);
    end

    // R10: write in the cycle of the lookup returns old entry
    cfg_mode = '0; clear_cap();
    flush(2);
    push_one(4, 512); push_one(4, 256); push_one(4, 0);
    lut_we = 1'b1; lut_ch = 4'd4; lut_addr = 6'd2; lut_wdata = 12'd999;
    push_one(4, 0);
    lut_we = 1'b0;
    flush(20);
    chk("R10 same-cycle read old", cap_h[4], 68);
    clear_cap();
    push_one(4, 512); push_one(4, 256);
    flush(20);
    chk("R10 new entry after write", cap_h[4], 999);

    // R12: gaps in the valid strobe with junk samples
    cfg_mode = '0; cfg_mode[6] = 1'b1; clear_cap();
    flush(2);
    idle(); push_one(6, 100); idle(); idle(); push_one(6, 200); idle();
    push_one(6, 300); pidx = cur_idx; idle(); push_one(6, 100); idle();
    flush(20);
    chk("R12 sum with gaps", cap_h[6], lut_val(6, 600));
    chk("R12 timestamp counts accepted samples", cap_ts[6], pidx % 256);
    chk("R12 single hit", cap_n[6], 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule